// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one up-counting timer channel. It has a run bit, a choice of count source and a bank of general registers. The counter advances on ticks from an internal divider or on edges of an external event input. Each general register works either as a compare register, which sets a flag and drives an output pin when the counter reaches its value, or as a capture register, which latches the running count on an edge of its capture pin.

Any compare-mode general register can be chosen to reset the counter after it matches. This gives a periodic counter whose cycle runs from zero up to the register value inclusive. When no register is chosen, the counter runs free and wraps through its full range.

Software reaches all state through a simple write port and a combinational read port.

The register map, with NREG general registers indexed i:
- Address 0 is control. Bit 0 is run. Bits 3:1 select the count source. Bits 5:4 select the external edge. Bits 8:6 select the clear register.
- Address 1 is the counter.
- Address 2 holds the flags.
- Address 4+2i is the value of general register i.
- Address 5+2i is the mode of general register i. Bit 0 selects capture. Bits 2:1 select the compare action. Bits 4:3 select the capture edge.

Top module: `cc_timer_chan`

## Requirements
- R1: The counter moves only upward, by one per count tick, and only while the run bit (control bit 0) is 1. While run is 0 the counter holds its value.
- R2: Count source codes 0, 1, 2 and 3 in control bits 3:1 give one tick every 1, 4, 16 or 64 clocks. The divider is held at zero while run is 0. T clocks after run is written to 1, the counter has advanced by floor(T/N).
- R3: Count source code 4 counts edges of the external event input. Codes 5 to 7 never advance the counter.
- R4: Edge select, in control bits 5:4, sets which external edges count: 00 counts rising edges, 01 counts falling edges, and 1x counts both. The input passes through two flip-flops. A change seen after clock edge D is counted at edge D+3.
- R5: Clear select values 0 to NREG-1, in control bits 8:6, name a compare-mode general register holding P. The counter then cycles 0, 1, ..., P, 0.
- R6: The counter runs free if clear select is NREG or above, or if it names a register in capture mode. In that case the counter wraps from all ones to zero.
- R7: Mode bit 0 sets each general register on its own: 1 makes it a capture register, 0 makes it a compare register. A compare register ignores its capture pin.
- R8: In capture mode, mode bits 4:3 select the capture edge, with the same encoding as R4. A capture pin change seen after edge D latches the count held after edge D+2, and sets that register's flag.
- R9: When a compare register's value equals the value the counter steps to, its flag is set. Its output then follows mode bits 2:1: 00 holds, 01 drives low, 10 drives high, 11 toggles.
- R10: Flag i is bit i at address 2. Writing a 1 to a bit clears that flag. A set in the same cycle wins over the clear.
- R11: After reset, all registers and outputs are zero. A counter write takes priority over counting, and the control register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data, combinational |
| ext_evt | input | 1 | External event input |
| cap_in | input | NREG | Capture pins, one per general register |
| cmp_out | output | NREG | Compare output pins, one per general register |

## Verification
The bench uses the defaults: a 16-bit counter, four general registers and four internal dividers up to 64. At this size every divider and every edge encoding can be swept. Periodic wrap points and compare toggles can be checked at each cycle, and the free-run wrap is reached by preloading the counter near all ones. Capture latency is checked at several offsets for each edge type, and the expected values are computed from cycle arithmetic.

// File: rtl/cct_pkg.sv
package cct_pkg;

   localparam int CTRL_W = 9;
   localparam int MODE_W = 5;

   localparam int A_CTRL = 0;
   localparam int A_CNT  = 1;
   localparam int A_FLAG = 2;
   localparam int A_GR0  = 4;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'b00,
      EDGE_FALL  = 2'b01,
      EDGE_ANY   = 2'b10,
      EDGE_ANY_B = 2'b11
   } edge_e;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   typedef struct packed {
      logic [2:0] clr_sel;
      edge_e      edge_sel;
      logic [2:0] src_sel;
      logic       run;
   } ctrl_t;

   typedef struct packed {
      edge_e cap_edge;
      act_e  act;
      logic  capture;
   } mode_t;

   function automatic logic edge_hit(edge_e sel, logic cur, logic prev);
      case (sel)
         EDGE_RISE: return cur & ~prev;
         EDGE_FALL: return ~cur & prev;
         default:   return cur ^ prev;
      endcase
   endfunction

endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          din,
   input  cct_pkg::edge_e edge_sel,
   output logic          hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cct_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign hit = cct_pkg::edge_hit(edge_sel, chain[STAGES-1], chain[STAGES]);
endmodule

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
   parameter int N_INT        = 4,
   parameter int PRE_LOG_STEP = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [2:0]     src_sel,
   input  cct_pkg::edge_e edge_sel,
   input  logic           ext_evt,
   output logic           step
);
   localparam int         PRE_W    = PRE_LOG_STEP * (N_INT - 1);
   localparam logic [2:0] EXT_CODE = 3'(N_INT);

   if (N_INT < 2 || N_INT > 7) begin : g_bad_nint
      $error("cct_tick_gen: N_INT must be 2..7");
   end
   if (PRE_LOG_STEP < 1) begin : g_bad_step
      $error("cct_tick_gen: PRE_LOG_STEP must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [N_INT-1:0] tick;
   logic             ext_hit;
   logic             sel_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (!run) pre_q <= '0;
      else           pre_q <= pre_q + PRE_W'(1);
   end

   for (genvar k = 0; k < N_INT; k++) begin : g_div
      if (k == 0) begin : g_full
         assign tick[k] = 1'b1;
      end else begin : g_part
         assign tick[k] = &pre_q[k*PRE_LOG_STEP-1:0];
      end
   end

   cct_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (ext_evt),
      .edge_sel (edge_sel),
      .hit      (ext_hit)
   );

   always_comb begin
      sel_tick = 1'b0;
      for (int k = 0; k < N_INT; k++) begin
         if (src_sel == 3'(k)) sel_tick = tick[k];
      end
      if (src_sel == EXT_CODE) sel_tick = ext_hit;
   end

   assign step = run & sel_tick;
endmodule

// File: rtl/cct_gen_reg.sv
module cct_gen_reg #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_val,
   input  logic                wr_mode,
   input  logic [CNT_W-1:0]    wdata,
   input  logic                flag_clr,
   input  logic [CNT_W-1:0]    cnt,
   input  logic [CNT_W-1:0]    cnt_nxt,
   input  logic                stepped,
   input  logic                cap_pin,
   output logic [CNT_W-1:0]    val,
   output cct_pkg::mode_t      mode,
   output logic                flag,
   output logic                pin_out
);
   import cct_pkg::*;

   logic cap_edge;
   logic cap_hit;
   logic match;

   cct_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (cap_pin),
      .edge_sel (mode.cap_edge),
      .hit      (cap_edge)
   );

   assign cap_hit = mode.capture & cap_edge;
   assign match   = ~mode.capture & stepped & (cnt_nxt == val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val  <= '0;
         mode <= '0;
      end else begin
         if (wr_val)       val <= wdata;
         else if (cap_hit) val <= cnt;
         if (wr_mode)      mode <= mode_t'(wdata[MODE_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag <= 1'b0;
      else if (cap_hit | match) flag <= 1'b1;
      else if (flag_clr)        flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_out <= 1'b0;
      else if (match) begin
         case (mode.act)
            ACT_LOW:    pin_out <= 1'b0;
            ACT_HIGH:   pin_out <= 1'b1;
            ACT_TOGGLE: pin_out <= ~pin_out;
            default:    pin_out <= pin_out;
         endcase
      end
   end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
   parameter int CNT_W        = 16,
   parameter int NREG         = 4,
   parameter int N_INT        = 4,
   parameter int PRE_LOG_STEP = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int ADDR_W       = $clog2(2 * NREG + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              ext_evt,
   input  logic [NREG-1:0]   cap_in,
   output logic [NREG-1:0]   cmp_out
);
   import cct_pkg::*;

   if (NREG < 1 || NREG > 7) begin : g_bad_nreg
      $error("cc_timer_chan: NREG must be 1..7");
   end
   if (CNT_W < CTRL_W) begin : g_bad_cntw
      $error("cc_timer_chan: CNT_W too narrow for control register");
   end
   if (ADDR_W < $clog2(2 * NREG + 4)) begin : g_bad_aw
      $error("cc_timer_chan: ADDR_W too narrow for register map");
   end

   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_CNT  = ADDR_W'(A_CNT);
   localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(A_FLAG);

   ctrl_t              ctrl_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_nxt;
   logic               step;
   logic               cnt_wr;
   logic               stepped;
   logic               clr_hit;
   logic [CNT_W-1:0]   gr_val  [NREG];
   mode_t              gr_mode [NREG];
   logic [NREG-1:0]    flag_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_q <= '0;
      else if (wr_en && wr_addr == AD_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   cct_tick_gen #(
      .N_INT        (N_INT),
      .PRE_LOG_STEP (PRE_LOG_STEP),
      .SYNC_STAGES  (SYNC_STAGES)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q.run),
      .src_sel  (ctrl_q.src_sel),
      .edge_sel (ctrl_q.edge_sel),
      .ext_evt  (ext_evt),
      .step     (step)
   );

   // Period clear: selected register must be a compare register at its value
   always_comb begin
      clr_hit = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (ctrl_q.clr_sel == 3'(i) && !gr_mode[i].capture && cnt_q == gr_val[i])
            clr_hit = 1'b1;
      end
   end

   assign cnt_nxt = clr_hit ? '0 : cnt_q + CNT_W'(1);
   assign cnt_wr  = wr_en && (wr_addr == AD_CNT);
   assign stepped = step & ~cnt_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (cnt_wr)  cnt_q <= wr_data;
      else if (step)    cnt_q <= cnt_nxt;
   end

   for (genvar i = 0; i < NREG; i++) begin : g_gr
      localparam logic [ADDR_W-1:0] AD_VAL  = ADDR_W'(A_GR0 + 2 * i);
      localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_GR0 + 2 * i + 1);

      cct_gen_reg #(
         .CNT_W       (CNT_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_gr (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_val   (wr_en && wr_addr == AD_VAL),
         .wr_mode  (wr_en && wr_addr == AD_MODE),
         .wdata    (wr_data),
         .flag_clr (wr_en && wr_addr == AD_FLAG && wr_data[i]),
         .cnt      (cnt_q),
         .cnt_nxt  (cnt_nxt),
         .stepped  (stepped),
         .cap_pin  (cap_in[i]),
         .val      (gr_val[i]),
         .mode     (gr_mode[i]),
         .flag     (flag_vec[i]),
         .pin_out  (cmp_out[i])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == AD_CTRL) rd_data = CNT_W'(ctrl_q);
      if (rd_addr == AD_CNT)  rd_data = cnt_q;
      if (rd_addr == AD_FLAG) rd_data = CNT_W'(flag_vec);
      for (int i = 0; i < NREG; i++) begin
         if (rd_addr == ADDR_W'(A_GR0 + 2 * i))     rd_data = gr_val[i];
         if (rd_addr == ADDR_W'(A_GR0 + 2 * i + 1)) rd_data = CNT_W'(gr_mode[i]);
      end
   end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
   parameter int CNT_W  = 16,
   parameter int NREG   = 4,
   parameter int N_INT  = 4,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              run,
   input logic [2:0]        src_sel,
   input logic              step,
   input logic [CNT_W-1:0]  cnt,
   input logic [NREG-1:0]   flags,
   input logic              sel_hit
);
   logic cnt_wr;
   logic flag_wr;
   assign cnt_wr  = wr_en && wr_addr == ADDR_W'(cct_pkg::A_CNT);
   assign flag_wr = wr_en && wr_addr == ADDR_W'(cct_pkg::A_FLAG);

   p_hold_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_wr && !sel_hit) |=> cnt == $past(cnt) + CNT_W'(1));

   p_period_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_wr && sel_hit) |=> cnt == '0);

   p_bad_source_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel > 3'(N_INT)) |-> !step);

   p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> (flags & $past(flags)) == $past(flags));
endmodule

bind cc_timer_chan cct_checker #(
   .CNT_W  (CNT_W),
   .NREG   (NREG),
   .N_INT  (N_INT),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .run     (ctrl_q.run),
   .src_sel (ctrl_q.src_sel),
   .step    (step),
   .cnt     (cnt_q),
   .flags   (flag_vec),
   .sel_hit (clr_hit)
);

// File: tb/cc_timer_chan_tb.sv
module cc_timer_chan_tb;
   localparam int CW = 16;
   localparam int NR = 4;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic          ext_evt = 1'b0;
   logic [NR-1:0] cap_in = '0;
   logic [NR-1:0] cmp_out;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cc_timer_chan #(.CNT_W(CW), .NREG(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_evt(ext_evt), .cap_in(cap_in), .cmp_out(cmp_out)
   );

   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      rd_addr = AW'(a);
      #1;
      d = int'(rd_data);
   endtask

   function automatic int mk_ctrl(int run, int src, int edg, int clr);
      return (clr << 6) | (edg << 4) | (src << 1) | run;
   endfunction

   task automatic restart(int src, int edg, int clr, int start_cnt);
      wr(0, mk_ctrl(0, src, edg, clr));
      wr(1, start_cnt);
      wr(0, mk_ctrl(1, src, edg, clr));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      for (int a = 0; a < 12; a++) begin
         rd(a, v); check("R11 reset read", v, 0);
      end
      check("R11 reset pins", int'(cmp_out), 0);
      wr(0, mk_ctrl(0, 3, 2, 5));
      rd(0, v); check("R11 ctrl readback", v, mk_ctrl(0, 3, 2, 5));

      // R1 hold while stopped
      wr(1, 5);
      repeat (10) @(negedge clk);
      rd(1, v); check("R1 stopped hold", v, 5);

      // R2 divider sweep
      for (int s = 0; s < 4; s++) begin
         for (int t = 0; t < 10; t++) begin
            int tt;
            int n;
            n = 1 << (2 * s);
            tt = t * (s + 1) * 7 + t;
            restart(s, 0, 7, 0);
            repeat (tt) @(negedge clk);
            rd(1, v); check("R2 divide count", v, tt / n);
         end
      end

      // R3 undefined source codes
      for (int s = 5; s < 8; s++) begin
         restart(s, 0, 7, 9);
         repeat (20) @(negedge clk);
         rd(1, v); check("R3 idle source", v, 9);
      end

      // R6 free-run wrap
      restart(0, 0, 7, 16'hFFFD);
      repeat (5) @(negedge clk);
      rd(1, v); check("R6 wrap", v, 2);

      // R5 periodic with toggle output on gr0
      wr(0, 0);
      wr(4, 4);
      wr(5, 6);
      wr(2, 15);
      restart(0, 0, 0, 0);
      for (int t = 1; t <= 14; t++) begin
         @(negedge clk);
         rd(1, v); check("R5 periodic count", v, t % 5);
         check("R9 toggle pin", int'(cmp_out[0]), ((t + 1) / 5) % 2);
      end
      rd(2, v); check("R9 match flag", v & 1, 1);
      wr(0, 0);
      wr(5, 0);

      // R6 clear source in capture mode runs free
      wr(6, 3);
      wr(7, 1);
      restart(0, 0, 1, 0);
      repeat (10) @(negedge clk);
      rd(1, v); check("R6 capture-mode source", v, 10);

      // R9 set and clear actions, hold action on gr3
      wr(0, 0);
      wr(7, 0);
      wr(8, 3);
      wr(9, 4);
      wr(10, 3);
      wr(11, 0);
      wr(2, 15);
      restart(0, 0, 7, 0);
      repeat (2) @(negedge clk);
      check("R9 before match", int'(cmp_out[2]), 0);
      @(negedge clk);
      check("R9 drive high", int'(cmp_out[2]), 1);
      check("R9 hold action", int'(cmp_out[3]), 0);
      rd(2, v); check("R9 flags set", v & 12, 12);
      wr(0, 0);
      wr(9, 2);
      restart(0, 0, 7, 0);
      repeat (2) @(negedge clk);
      check("R9 before low", int'(cmp_out[2]), 1);
      @(negedge clk);
      check("R9 drive low", int'(cmp_out[2]), 0);

      // R10 write one to clear
      wr(0, 0);
      wr(2, 4);
      rd(2, v); check("R10 partial clear", v & 12, 8);

      // R7 compare register ignores capture pin
      wr(8, 77);
      cap_in[2] = 1'b1;
      repeat (6) @(negedge clk);
      cap_in[2] = 1'b0;
      repeat (6) @(negedge clk);
      rd(8, v); check("R7 compare ignores pin", v, 77);

      // R4 external edges
      for (int e = 0; e < 3; e++) begin
         restart(4, e, 7, 0);
         for (int p = 0; p < 5; p++) begin
            ext_evt = 1'b1; repeat (4) @(negedge clk);
            ext_evt = 1'b0; repeat (4) @(negedge clk);
         end
         repeat (4) @(negedge clk);
         rd(1, v); check("R4 external count", v, (e == 2) ? 10 : 5);
      end
      wr(0, 0);
      ext_evt = 1'b1;
      wr(0, mk_ctrl(0, 4, 0, 7));
      wr(1, 0);
      wr(0, mk_ctrl(1, 4, 0, 7));
      ext_evt = 1'b0;
      repeat (3) @(negedge clk);
      rd(1, v); check("R4 latency not yet", v, 0);

      // R8 capture sweep on gr1
      for (int e = 0; e < 3; e++) begin
         for (int k = 0; k < 3; k++) begin
            int d;
            d = 3 + 6 * k;
            wr(0, 0);
            wr(7, 1 | (e << 3));
            cap_in[1] = (e == 1);
            repeat (5) @(negedge clk);
            wr(2, 15);
            restart(0, 0, 7, 0);
            repeat (d) @(negedge clk);
            cap_in[1] = ~cap_in[1];
            repeat (5) @(negedge clk);
            rd(6, v); check("R8 captured count", v, d + 2);
            rd(2, v); check("R8 capture flag", v & 2, 2);
         end
      end

      // R11 counter write beats counting
      restart(0, 0, 7, 0);
      wr(1, 1000);
      rd(1, v); check("R11 write priority", v, 1000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule